// File: doc/BRIEF.md
# Indirect MDIO management master

This block lets a host reach a small set of internal PHYs through a single 32-bit control word. The host writes the word in one cycle, supplying the target PHY number, the PHY register number, a read/write command, an enable flag, a start flag and, for writes, sixteen data bits. The block then runs one Clause 22 management frame on MDC/MDIO and signals completion by clearing the start flag, which it reports as busy. Once busy has cleared after a read, the low half of the word holds the value returned by the PHY.

MDC is produced from the system clock by a divider whose half-period is a parameter. The master changes MDIO only on falling MDC edges. During the turnaround and data phases of a read it releases the line and takes each data bit on a rising MDC edge. Requests aimed at a PHY number outside the populated range finish at once, with no bus activity. Requests written while a frame is in flight are dropped.

Top module: `mdio_ctl_master`

## Requirements
- R1: After reset the control word reads 0, MDC is low and the master is not driving MDIO (`mdio_oe` = 0).
- R2: A frame starts only when a write has bit 31 (busy) and bit 30 (enable) both set. A write with bit 31 set and bit 30 clear stores its fields, reads back with bit 31 clear, and causes no MDC or MDIO activity.
- R3: Every frame sends 32 ones, then start bits 01, then opcode 10 for a read (bit 27 = 1) or 01 for a write (bit 27 = 0), then the PHY number (word bits 25:21) and the register number (word bits 20:16), each MSB first.
- R4: A write frame continues with turnaround 10 and then word bits 15:0 MSB first. The master drives MDIO for the whole frame, and after completion the low 16 bits still hold the written data.
- R5: A read frame releases MDIO (`mdio_oe` = 0) from the first turnaround bit to the end of the frame. It samples 16 data bits on rising MDC edges, MSB first, and places them in word bits 15:0 when busy clears.
- R6: While a frame runs, each MDC high phase and each MDC low phase lasts MDC_HALF system clocks. MDC stays low while idle. `mdio_o` and `mdio_oe` never change on the clock edge that raises MDC.
- R7: Busy (bit 31) reads 1 for exactly 128*MDC_HALF clock cycles after the starting write and then clears. A frame has exactly 64 rising MDC edges.
- R8: A started request whose PHY number is NUM_PHYS (default 5) or more completes in the write cycle, with busy reading 0 and no bus activity. For a read it returns 0xFFFF in bits 15:0; for a write the written data stays in bits 15:0.
- R9: Writes to the control word while busy reads 1 are ignored. The running frame and word bits 30:16 are unchanged.
- R10: After a frame completes, word bits 30:16 read back exactly as written by the starting write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Control word value to write |
| reg_rdata | output | 32 | Current control word (busy, fields, data) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable; 0 releases the line |
| mdio_i | input | 1 | MDIO value seen on the line |

## Verification
If the bit index or the shift register goes wrong, the header or data bits on MDIO are wrong within the same frame, and the PHY model reports a mismatched header or turnaround at the 64th rising MDC edge. A wrong divider count shows up as an MDC phase of the wrong length on the next toggle, and busy then clears at the wrong cycle. A broken completion or start gate leaves busy stuck or lets MDC toggle after a rejected request. An off-by-one in the read capture window shifts the returned data by one bit, which the scoreboard sees as soon as busy drops.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 16;
  localparam int PRE_BITS  = 32;
  localparam int TA_IDX    = PRE_BITS + 4 + 2 * ADDR_W;
  localparam int FRAME_LEN = TA_IDX + 2 + DATA_W;

  localparam int B_BUSY = 31;
  localparam int B_EN   = 30;
  localparam int B_CMD  = 27;
  localparam int B_PHY  = 21;
  localparam int B_REG  = 16;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regad;
    logic [DATA_W-1:0] wdata;
  } mdio_req_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_ev,
  output logic fall_ev
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          wrap;

  assign wrap = (cnt_q == CW'(HALF - 1));

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc     = mdc_q;
  assign rise_ev = run && wrap && !mdc_q;
  assign fall_ev = run && wrap && mdc_q;
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  mdio_req_t         req,
  input  logic              rise_ev,
  input  logic              fall_ev,
  input  logic              mdio_i,
  output logic              active,
  output logic              done,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rx_data
);
  localparam int IW = $clog2(FRAME_LEN);

  logic                 act_q, act_d;
  logic                 rd_q, rd_d;
  logic [IW-1:0]        idx_q, idx_d;
  logic [FRAME_LEN-1:0] sr_q, sr_d;
  logic [DATA_W-1:0]    rx_q, rx_d;
  logic [FRAME_LEN-1:0] frame_w;
  logic                 last_bit;

  assign frame_w = {{PRE_BITS{1'b1}}, 2'b01,
                    req.rd ? 2'b10 : 2'b01,
                    req.phy, req.regad,
                    req.rd ? 2'b11 : 2'b10,
                    req.rd ? {DATA_W{1'b1}} : req.wdata};

  assign last_bit = (idx_q == IW'(FRAME_LEN - 1));

  always_comb begin
    act_d = act_q;
    rd_d  = rd_q;
    idx_d = idx_q;
    sr_d  = sr_q;
    rx_d  = rx_q;
    if (start) begin
      act_d = 1'b1;
      rd_d  = req.rd;
      idx_d = '0;
      sr_d  = frame_w;
      rx_d  = '0;
    end else if (act_q) begin
      if (rise_ev && rd_q && (idx_q >= IW'(TA_IDX + 2)))
        rx_d = {rx_q[DATA_W-2:0], mdio_i};
      if (fall_ev) begin
        if (last_bit) begin
          act_d = 1'b0;
        end else begin
          idx_d = idx_q + 1'b1;
          sr_d  = {sr_q[FRAME_LEN-2:0], 1'b1};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      rd_q  <= 1'b0;
      idx_q <= '0;
      sr_q  <= '1;
      rx_q  <= '0;
    end else begin
      act_q <= act_d;
      rd_q  <= rd_d;
      idx_q <= idx_d;
      sr_q  <= sr_d;
      rx_q  <= rx_d;
    end
  end

  assign active  = act_q;
  assign done    = act_q && fall_ev && last_bit;
  assign mdio_o  = act_q ? sr_q[FRAME_LEN-1] : 1'b1;
  assign mdio_oe = act_q && (!rd_q || (idx_q < IW'(TA_IDX)));
  assign rx_data = rx_q;
endmodule

// File: rtl/mdio_ctl_master.sv
module mdio_ctl_master
  import mdio_pkg::*;
#(
  parameter int MDC_HALF = 2,
  parameter int NUM_PHYS = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [31:0]       ctrl_q, ctrl_d;
  logic              ctrl_en;
  logic              busy, wr_ok, req_go, phy_ok, start;
  logic              run, rise_ev, fall_ev, done;
  logic [DATA_W-1:0] rx_data;
  mdio_req_t         req;

  assign busy   = ctrl_q[B_BUSY];
  assign wr_ok  = reg_wr && !busy;
  assign req_go = wr_ok && reg_wdata[B_BUSY] && reg_wdata[B_EN];
  assign phy_ok = int'(reg_wdata[B_PHY +: ADDR_W]) < NUM_PHYS;
  assign start  = req_go && phy_ok;

  assign req.rd    = reg_wdata[B_CMD];
  assign req.phy   = reg_wdata[B_PHY +: ADDR_W];
  assign req.regad = reg_wdata[B_REG +: ADDR_W];
  assign req.wdata = reg_wdata[DATA_W-1:0];

  always_comb begin
    ctrl_d  = ctrl_q;
    ctrl_en = wr_ok || done;
    if (wr_ok) begin
      ctrl_d         = reg_wdata;
      ctrl_d[B_BUSY] = start;
      if (req_go && !phy_ok && reg_wdata[B_CMD])
        ctrl_d[DATA_W-1:0] = '1;
    end else if (done) begin
      ctrl_d[B_BUSY] = 1'b0;
      if (ctrl_q[B_CMD])
        ctrl_d[DATA_W-1:0] = rx_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  mdio_clk_div #(.HALF(MDC_HALF)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .mdc     (mdc),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev)
  );

  mdio_frame_eng u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .req     (req),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev),
    .mdio_i  (mdio_i),
    .active  (run),
    .done    (done),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .rx_data (rx_data)
  );

  assign reg_rdata = ctrl_q;
endmodule

// File: rtl/mdio_ctl_master_chk.sv
module mdio_ctl_master_chk #(
  parameter int NUM_PHYS = 5
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        req_go,
  input logic        req_en,
  input logic [4:0]  req_phy,
  input logic [15:0] stat_hi,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  logic       busy, rd_cmd, mdc_q, rise;
  logic [6:0] rise_cnt;

  assign busy   = stat_hi[15];
  assign rd_cmd = stat_hi[11];
  assign rise   = mdc && !mdc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_q    <= 1'b0;
      rise_cnt <= '0;
    end else begin
      mdc_q <= mdc;
      if (!busy)     rise_cnt <= '0;
      else if (rise) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  p_no_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !busy && req_go && !req_en) |=> !busy);

  p_write_drives_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_cmd) |-> mdio_oe);

  p_read_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_cmd && rise && (rise_cnt >= 7'd46)) |-> !mdio_oe);

  p_stable_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> ($stable(mdio_o) && $stable(mdio_oe)));

  p_frame_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rise_cnt <= 7'd64);

  p_bad_phy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !busy && req_go && req_en && (int'(req_phy) >= NUM_PHYS)) |=> !busy);

  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(stat_hi[14:0]));
endmodule

bind mdio_ctl_master mdio_ctl_master_chk #(.NUM_PHYS(NUM_PHYS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .reg_wr  (reg_wr),
  .req_go  (reg_wdata[31]),
  .req_en  (reg_wdata[30]),
  .req_phy (reg_wdata[25:21]),
  .stat_hi (reg_rdata[31:16]),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe)
);

// File: tb/tb_mdio_ctl_master.sv
`timescale 1ns/1ps
module tb_mdio_ctl_master;
  localparam int DIV   = 2;
  localparam int NPHY  = 5;
  localparam int FLEN  = 128 * DIV;

  logic        clk, rst_n, reg_wr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;
  logic        slave_drv;

  int checks = 0;
  int errors = 0;

  assign mdio_i = mdio_oe ? mdio_o : slave_drv;

  mdio_ctl_master #(.MDC_HALF(DIV), .NUM_PHYS(NPHY)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [15:0] init_val(int p, int r);
    return {4'hC, 1'b0, 3'(p), 5'(r), 3'b101};
  endfunction

  function automatic logic [31:0] mk_word(logic go, logic en, logic rd,
                                          logic [4:0] p, logic [4:0] r, logic [15:0] d);
    return {go, en, 2'b00, rd, 1'b0, p, r, d};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // PHY model
  logic [15:0] phy_mem [NPHY][32];
  logic [63:0] cap;
  int          pcnt;
  logic        mdc_s;
  logic [15:0] rd_word;
  logic        rd_frame;
  logic [13:0] last_hdr;
  logic        last_pre;
  logic [1:0]  last_ta;
  logic [15:0] last_data;

  always @(negedge clk) begin
    logic [63:0] cn;
    logic        b;
    if (!rst_n) begin
      for (int p = 0; p < NPHY; p++)
        for (int r = 0; r < 32; r++) phy_mem[p][r] <= init_val(p, r);
      pcnt <= 0; mdc_s <= 1'b0; slave_drv <= 1'b1; cap <= '0;
      rd_word <= '0; rd_frame <= 1'b0;
      last_hdr <= '0; last_pre <= 1'b0; last_ta <= '0; last_data <= '0;
    end else begin
      mdc_s <= mdc;
      if (!reg_rdata[31]) begin
        pcnt <= 0; slave_drv <= 1'b1;
      end else if (mdc && !mdc_s) begin
        b  = mdio_oe ? mdio_o : slave_drv;
        cn = {cap[62:0], b};
        cap  <= cn;
        pcnt <= pcnt + 1;
        if (pcnt == 63) begin
          last_pre  <= &cn[63:32];
          last_hdr  <= cn[31:18];
          last_ta   <= cn[17:16];
          last_data <= cn[15:0];
          if (cn[29:28] == 2'b01 && int'(cn[27:23]) < NPHY)
            phy_mem[cn[27:23]][cn[22:18]] <= cn[15:0];
        end
      end else if (!mdc && mdc_s) begin
        if (pcnt == 46) begin
          rd_frame <= (cap[11:10] == 2'b10);
          if (int'(cap[9:5]) < NPHY) rd_word <= phy_mem[cap[9:5]][cap[4:0]];
          slave_drv <= 1'b1;
        end else if (pcnt == 47 && rd_frame) slave_drv <= 1'b0;
        else if (pcnt >= 48 && pcnt <= 63 && rd_frame) slave_drv <= rd_word[63 - pcnt];
        else slave_drv <= 1'b1;
      end
    end
  end

  // Scoreboard
  typedef struct {
    logic        rd;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] wd;
    logic [15:0] low;
    logic [14:0] hi;
  } exp_t;
  exp_t        sb_q[$];
  logic [15:0] ref_mem [NPHY][32];

  always @(negedge clk) begin
    static logic busy_p = 1'b0;
    static int   blen = 0;
    static logic mdc_p = 1'b0;
    static int   run = 0;
    exp_t e;
    if (rst_n) begin
      if (mdc == mdc_p) run++;
      else begin
        if (mdc_p) chk(run == DIV, "R6 mdc high phase", run, DIV);
        run = 1;
      end
      mdc_p = mdc;
      if (reg_rdata[31]) blen++;
      if (busy_p && !reg_rdata[31]) begin
        if (sb_q.size() == 0) chk(0, "R7 unexpected completion", 0, 1);
        else begin
          e = sb_q.pop_front();
          chk(blen == FLEN, "R7 busy length", blen, FLEN);
          chk(last_pre, "R3 preamble", {31'd0, last_pre}, 1);
          chk(last_hdr == {2'b01, e.rd ? 2'b10 : 2'b01, e.phy, e.rg}, "R3 header",
              {18'd0, last_hdr}, {18'd0, 2'b01, e.rd ? 2'b10 : 2'b01, e.phy, e.rg});
          if (!e.rd) begin
            chk(last_ta == 2'b10, "R4 turnaround", {30'd0, last_ta}, 2);
            chk(last_data == e.wd, "R4 data on wire", {16'd0, last_data}, {16'd0, e.wd});
          end
          chk(reg_rdata[15:0] == e.low, e.rd ? "R5 read data" : "R4 data kept",
              {16'd0, reg_rdata[15:0]}, {16'd0, e.low});
          chk(reg_rdata[30:16] == e.hi, "R10 fields", {17'd0, reg_rdata[30:16]}, {17'd0, e.hi});
        end
        blen = 0;
      end
      if (!reg_rdata[31]) blen = 0;
      busy_p = reg_rdata[31];
    end
  end

  task automatic write_reg(logic [31:0] w);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = w;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic issue_begin(logic rd, logic [4:0] p, logic [4:0] r, logic [15:0] d);
    exp_t e;
    logic [31:0] w;
    w = mk_word(1'b1, 1'b1, rd, p, r, d);
    e.rd = rd; e.phy = p; e.rg = r; e.wd = d; e.hi = w[30:16];
    e.low = rd ? ref_mem[p][r] : d;
    if (!rd) ref_mem[p][r] = d;
    sb_q.push_back(e);
    write_reg(w);
  endtask

  task automatic wait_done();
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic issue(logic rd, logic [4:0] p, logic [4:0] r, logic [15:0] d);
    issue_begin(rd, p, r, d);
    wait_done();
  endtask

  task automatic quiet(int n, string req);
    bit ok = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mdc || mdio_oe || reg_rdata[31]) ok = 0;
    end
    chk(ok, req, {29'd0, mdc, mdio_oe, reg_rdata[31]}, 0);
  endtask

  initial begin
    for (int p = 0; p < NPHY; p++)
      for (int r = 0; r < 32; r++) ref_mem[p][r] = init_val(p, r);
    rst_n = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    chk(reg_rdata == 32'd0, "R1 reset word", reg_rdata, 0);
    chk(!mdc && !mdio_oe, "R1 reset bus", {30'd0, mdc, mdio_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    issue(1'b0, 5'd1, 5'd3, 16'h1234);
    issue(1'b1, 5'd1, 5'd3, 16'h0000);
    issue(1'b1, 5'd4, 5'd31, 16'h0000);
    issue(1'b0, 5'd0, 5'd0, 16'hFFFF);
    issue(1'b1, 5'd0, 5'd0, 16'h0000);
    issue(1'b0, 5'd2, 5'd17, 16'h0000);
    issue(1'b1, 5'd2, 5'd17, 16'hAAAA);
    issue(1'b1, 5'd3, 5'd9, 16'h0000);

    // R2: start without enable
    write_reg(mk_word(1'b1, 1'b0, 1'b1, 5'd1, 5'd5, 16'h4321));
    chk(reg_rdata == mk_word(1'b0, 1'b0, 1'b1, 5'd1, 5'd5, 16'h4321), "R2 no enable word",
        reg_rdata, mk_word(1'b0, 1'b0, 1'b1, 5'd1, 5'd5, 16'h4321));
    quiet(40, "R2 no enable quiet");

    // R8: out-of-range PHY
    write_reg(mk_word(1'b1, 1'b1, 1'b1, 5'd5, 5'd2, 16'h0000));
    chk(reg_rdata == mk_word(1'b0, 1'b1, 1'b1, 5'd5, 5'd2, 16'hFFFF), "R8 bad read",
        reg_rdata, mk_word(1'b0, 1'b1, 1'b1, 5'd5, 5'd2, 16'hFFFF));
    quiet(40, "R8 bad read quiet");
    write_reg(mk_word(1'b1, 1'b1, 1'b0, 5'd31, 5'd7, 16'h5A5A));
    chk(reg_rdata == mk_word(1'b0, 1'b1, 1'b0, 5'd31, 5'd7, 16'h5A5A), "R8 bad write",
        reg_rdata, mk_word(1'b0, 1'b1, 1'b0, 5'd31, 5'd7, 16'h5A5A));
    quiet(40, "R8 bad write quiet");

    // R9: write while busy is dropped
    issue_begin(1'b0, 5'd2, 5'd7, 16'hBEEF);
    repeat (10) @(negedge clk);
    write_reg(mk_word(1'b1, 1'b1, 1'b1, 5'd3, 5'd1, 16'h0000));
    chk(reg_rdata[30:16] == mk_word(1'b1, 1'b1, 1'b0, 5'd2, 5'd7, 16'h0)[30:16],
        "R9 fields held", {17'd0, reg_rdata[30:16]},
        {17'd0, mk_word(1'b1, 1'b1, 1'b0, 5'd2, 5'd7, 16'h0)[30:16]});
    wait_done();
    quiet(20, "R9 no second frame");
    issue(1'b1, 5'd2, 5'd7, 16'h0000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule